// File: doc/BRIEF.md
# System Control Register File

This block is a 4 KiB window of 32-bit general-purpose registers behind an APB-style slave port. Software stores any value in any word and reads it back unchanged. A few words behave differently. Four words near the start of the window come out of reset holding fixed identification codes. Three status words always read with bits 29 and 28 set, although those bits are never written into storage.

One control word near the top of the window also acts as a command port. Writing a reset code to it makes the block emit a one-cycle system reset request. Writing the power-off code makes it emit a one-cycle shutdown request. A separate reset controller and power sequencer act on these pulses. The control word still stores the written value like any other word.

Top module: `sysctl_regfile`

## Requirements
- R1: A completed write (psel, penable and pwrite high at a clock edge) stores pwdata into the word at index paddr[11:2]. A later read of that word returns the stored value, unless R4 applies.
- R2: After reset, the words at byte offsets 0x100, 0x104, 0x108 and 0x10C hold 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121 respectively.
- R3: After reset, every other word holds zero.
- R4: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000. The stored value is unchanged, so a read at 0x104 or at any other offset shows no forced bits.
- R5: A completed write to byte offset 0xF00 with data 1 or 2 drives rst_req high for exactly the one cycle after the write edge.
- R6: A completed write to byte offset 0xF00 with data 3 drives off_req high for exactly the one cycle after the write edge.
- R7: A write to 0xF00 with any other data, and a write of 1, 2 or 3 to any other offset, raises neither request. The two requests are never high together.
- R8: The control word at 0xF00 stores every value written to it, command codes included, and reads it back.
- R9: pready is always high. A setup phase with no access phase writes nothing, and reads have no side effect.
- R10: paddr[1:0] are ignored. Offsets 0x200 and 0x203 address the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational in the access phase |
| pready | output | 1 | Transfer ready, tied high |
| rst_req | output | 1 | One-cycle system reset request |
| off_req | output | 1 | One-cycle shutdown request |

## Verification
Store-and-readback is exercised with all-ones, all-zeros, alternating and walking patterns. These are applied to plain words, to the forced status words, to the identification word that is not forced, and to addresses with nonzero low bits. Together they show whether the masking is applied on the read path or wrongly stored, and whether it is limited to the three named offsets. The command word is driven with codes 0 to 4 and with near-miss addresses. This separates the reset pulse from the shutdown pulse, shows that unmatched codes raise nothing, and confirms that each pulse lasts one cycle. A reset applied after the words have been overwritten confirms that the identification values come back and that the other words return to zero.

// File: rtl/sysctl_pkg.sv
// Package: constants shared by the system control register file.
// Assumes 32-bit words and a byte-addressed 12-bit window.
package sysctl_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned ID_COUNT   = 4;
    localparam int unsigned ID_BASE    = 'h40;
    localparam int unsigned CTRL_INDEX = 'h3C0;   // byte offset 0xF00
    localparam int unsigned NUM_FORCED = 3;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t CODE_RESET_A = 32'd1;
    localparam word_t CODE_RESET_B = 32'd2;
    localparam word_t CODE_POWEROFF = 32'd3;
    localparam word_t FORCE_BITS   = 32'h3000_0000;

    // Word indices whose read data carries the forced bits.
    localparam int unsigned FORCED_INDEX [NUM_FORCED] = '{'h40, 'h42, 'h43};

    // Identification values loaded into words ID_BASE .. ID_BASE+3.
    localparam word_t ID_VALUE [ID_COUNT] =
        '{32'h05F2_0121, 32'h0000_0002, 32'h05F3_0121, 32'h05F4_0121};

    // Reset value of word idx: identification codes or zero.
    function automatic word_t reset_value(input int unsigned idx);
        word_t v;
        v = '0;
        for (int k = 0; k < ID_COUNT; k++) begin
            if (idx == ID_BASE + k) v = ID_VALUE[k];
        end
        return v;
    endfunction

endpackage

// File: rtl/sysctl_store.sv
// Module: word storage of the register file.
// One write port and one combinational read port; synchronous
// active-low reset loads each word with its reset value.
// Assumes wr_idx and rd_idx are always within DEPTH.
module sysctl_store #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Load reset values, otherwise capture a completed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DATA_W'(sysctl_pkg::reset_value(i));
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Return the addressed word.
    always_comb begin
        rd_data = mem[rd_idx];
    end

endmodule

// File: rtl/sysctl_cmd.sv
// Module: command decoder for the control word.
// Watches completed writes and emits registered one-cycle reset or
// shutdown requests. Assumes wr_en is high for one cycle per write.
module sysctl_cmd #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned CTRL   = 'h3C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_req,
    output logic              off_req
);

    logic ctrl_hit;
    logic want_reset;
    logic want_off;

    // Classify the current write against the command codes.
    always_comb begin
        ctrl_hit   = wr_en && (wr_idx == IDX_W'(CTRL));
        want_reset = ctrl_hit &&
                     ((wr_data == DATA_W'(sysctl_pkg::CODE_RESET_A)) ||
                      (wr_data == DATA_W'(sysctl_pkg::CODE_RESET_B)));
        want_off   = ctrl_hit && (wr_data == DATA_W'(sysctl_pkg::CODE_POWEROFF));
    end

    // Register the requests so each lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            off_req <= 1'b0;
        end else begin
            rst_req <= want_reset;
            off_req <= want_off;
        end
    end

endmodule

// File: rtl/sysctl_rdmask.sv
// Module: read-path overlay.
// ORs fixed bits into the read data of selected words. Storage is
// never touched. Assumes the forced list in the package is short.
module sysctl_rdmask #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 10
) (
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] raw_data,
    output logic [DATA_W-1:0] out_data
);

    localparam int unsigned NF = sysctl_pkg::NUM_FORCED;

    logic [NF-1:0] hit;

    // One comparator per forced word index.
    for (genvar g = 0; g < NF; g++) begin : g_match
        assign hit[g] = (rd_idx == IDX_W'(sysctl_pkg::FORCED_INDEX[g]));
    end

    // Apply the mask when any comparator matches.
    always_comb begin
        out_data = raw_data;
        if (|hit) out_data = raw_data | DATA_W'(sysctl_pkg::FORCE_BITS);
    end

endmodule

// File: rtl/sysctl_regfile.sv
// Module: system control register file, top level.
// APB-style slave, always ready, word accesses only (paddr[1:0]
// ignored). Writes complete in the access phase. Read data is
// combinational from the addressed word during the access phase.
module sysctl_regfile #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              rst_req,
    output logic              off_req
);

    localparam int unsigned DEPTH = (1 << ADDR_W) / 4;
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic             wr_en;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] raw_rd;
    logic [DATA_W-1:0] masked_rd;

    // Decode a completed write and the word index.
    always_comb begin
        wr_en  = psel && penable && pwrite;
        idx    = paddr[ADDR_W-1:2];
        pready = 1'b1;
    end

    sysctl_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (pwdata),
        .rd_idx  (idx),
        .rd_data (raw_rd)
    );

    sysctl_rdmask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
        .rd_idx   (idx),
        .raw_data (raw_rd),
        .out_data (masked_rd)
    );

    sysctl_cmd #(.DATA_W(DATA_W), .IDX_W(IDX_W),
                 .CTRL(sysctl_pkg::CTRL_INDEX)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (pwdata),
        .rst_req (rst_req),
        .off_req (off_req)
    );

    // Drive read data only during a read access.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) prdata = masked_rd;
    end

endmodule

// File: rtl/sysctl_regfile_chk.sv
// Module: assertion checker for sysctl_regfile, attached by bind.
module sysctl_regfile_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              rst_req,
    input logic              off_req
);

    localparam logic [ADDR_W-1:2] CTRL_W = (ADDR_W-2)'(sysctl_pkg::CTRL_INDEX);

    logic forced_addr;
    always_comb begin
        forced_addr = (paddr[ADDR_W-1:2] == (ADDR_W-2)'('h40)) ||
                      (paddr[ADDR_W-1:2] == (ADDR_W-2)'('h42)) ||
                      (paddr[ADDR_W-1:2] == (ADDR_W-2)'('h43));
    end

    // R5: a reset request follows only a reset-code write to the control word
    p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(psel && penable && pwrite &&
                          paddr[ADDR_W-1:2] == CTRL_W &&
                          (pwdata == 32'd1 || pwdata == 32'd2)));

    // R6: a shutdown request follows only a power-off write
    p_off_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> $past(psel && penable && pwrite &&
                          paddr[ADDR_W-1:2] == CTRL_W && pwdata == 32'd3));

    // R7: the two requests never coincide
    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && off_req));

    // R4: forced status words always show bits 29 and 28
    p_forced_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && forced_addr) |-> (prdata[29:28] == 2'b11));

    // R1: a read right after a write to the same plain word returns its data
    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && !forced_addr &&
         $past(psel && penable && pwrite) &&
         paddr[ADDR_W-1:2] == $past(paddr[ADDR_W-1:2]))
        |-> (prdata == $past(pwdata)));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .rst_req (rst_req),
    .off_req (off_req)
);

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        rst_req;
    logic        off_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    sysctl_regfile dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .rst_req(rst_req), .off_req(off_req)
    );

    // Vector table: write address, data, read address, expected read.
    localparam int NV = 10;
    localparam logic [11:0] V_WA [NV] = '{12'h000, 12'h004, 12'h200, 12'h7F8,
                                           12'h108, 12'h104, 12'h10C, 12'h3FC,
                                           12'hFFC, 12'h100};
    localparam logic [31:0] V_WD [NV] = '{32'hFFFF_FFFF, 32'h0000_0000,
                                           32'hA5A5_5A5A, 32'h0000_0001,
                                           32'h0000_0000, 32'hFFFF_FFFF,
                                           32'h8000_0001, 32'h5555_5555,
                                           32'hCAFE_F00D, 32'hC000_0000};
    localparam logic [11:0] V_RA [NV] = '{12'h000, 12'h006, 12'h203, 12'h7F9,
                                           12'h108, 12'h104, 12'h10E, 12'h3FC,
                                           12'hFFC, 12'h100};
    localparam logic [31:0] V_EX [NV] = '{32'hFFFF_FFFF, 32'h0000_0000,
                                           32'hA5A5_5A5A, 32'h0000_0001,
                                           32'h3000_0000, 32'hFFFF_FFFF,
                                           32'hB000_0001, 32'h5555_5555,
                                           32'hCAFE_F00D, 32'hF000_0000};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Full write; returns the request outputs in the cycle after the write edge.
    task automatic apb_write(input logic [11:0] a, input logic [31:0] d,
                             output logic got_rst, output logic got_off);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        got_rst = rst_req; got_off = off_req;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Write to the control word and check both pulses and their width.
    task automatic ctrl_case(input logic [11:0] a, input logic [31:0] d,
                             input logic exp_rst, input logic exp_off,
                             input string req);
        logic r, o;
        apb_write(a, d, r, o);
        check(r == exp_rst, req, {31'd0, r}, {31'd0, exp_rst});
        check(o == exp_off, req, {31'd0, o}, {31'd0, exp_off});
        @(negedge clk);
        check(!rst_req && !off_req, req, {30'd0, rst_req, off_req}, 32'd0);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic r, o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 / R4: identification words after reset
        apb_read(12'h100, rd); check(rd == 32'h35F2_0121, "R2", rd, 32'h35F2_0121);
        apb_read(12'h104, rd); check(rd == 32'h0000_0002, "R2", rd, 32'h0000_0002);
        apb_read(12'h108, rd); check(rd == 32'h35F3_0121, "R2", rd, 32'h35F3_0121);
        apb_read(12'h10C, rd); check(rd == 32'h35F4_0121, "R2", rd, 32'h35F4_0121);
        // R3: other words zero
        apb_read(12'h000, rd); check(rd == 32'h0, "R3", rd, 32'h0);
        apb_read(12'h110, rd); check(rd == 32'h0, "R3", rd, 32'h0);
        apb_read(12'hF00, rd); check(rd == 32'h0, "R3", rd, 32'h0);
        // R9: pready tied high, no request out of reset
        check(pready == 1'b1, "R9", {31'd0, pready}, 32'd1);
        check(!rst_req && !off_req, "R7", {30'd0, rst_req, off_req}, 32'd0);

        // R1 / R4 / R10: vector table
        for (int i = 0; i < NV; i++) begin
            apb_write(V_WA[i], V_WD[i], r, o);
            apb_read(V_RA[i], rd);
            check(rd == V_EX[i], "R1/R4/R10", rd, V_EX[i]);
        end
        // R4: repeated reads of a forced word are stable
        apb_read(12'h108, rd); check(rd == 32'h3000_0000, "R4", rd, 32'h3000_0000);

        // R5 / R6 / R7 / R8: control word
        ctrl_case(12'hF00, 32'd1, 1'b1, 1'b0, "R5");
        apb_read(12'hF00, rd); check(rd == 32'd1, "R8", rd, 32'd1);
        ctrl_case(12'hF00, 32'd2, 1'b1, 1'b0, "R5");
        ctrl_case(12'hF00, 32'd3, 1'b0, 1'b1, "R6");
        apb_read(12'hF00, rd); check(rd == 32'd3, "R8", rd, 32'd3);
        ctrl_case(12'hF00, 32'd4, 1'b0, 1'b0, "R7");
        ctrl_case(12'hF00, 32'd0, 1'b0, 1'b0, "R7");
        ctrl_case(12'hF00, 32'h1_0001, 1'b0, 1'b0, "R7");
        ctrl_case(12'hF04, 32'd1, 1'b0, 1'b0, "R7");
        ctrl_case(12'hEFC, 32'd3, 1'b0, 1'b0, "R7");
        ctrl_case(12'hF02, 32'd3, 1'b0, 1'b1, "R10");
        apb_read(12'hF00, rd); check(rd == 32'd3, "R8", rd, 32'd3);

        // R9: setup phase alone writes nothing
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h300; pwdata = 32'hDEAD_BEEF;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        apb_read(12'h300, rd); check(rd == 32'h0, "R9", rd, 32'h0);
        // R9: a read of the control word raises no request
        @(negedge clk);
        psel = 1'b1; paddr = 12'hF00;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        check(!rst_req && !off_req, "R9", {30'd0, rst_req, off_req}, 32'd0);
        psel = 1'b0; penable = 1'b0;

        // R2 / R3: reset after overwrites restores values
        apb_write(12'h104, 32'h1234_5678, r, o);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        apb_read(12'h104, rd); check(rd == 32'h0000_0002, "R2", rd, 32'h0000_0002);
        apb_read(12'h100, rd); check(rd == 32'h35F2_0121, "R2", rd, 32'h35F2_0121);
        apb_read(12'h200, rd); check(rd == 32'h0, "R3", rd, 32'h0);
        apb_read(12'hF00, rd); check(rd == 32'h0, "R3", rd, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule